// File: doc/BRIEF.md
# Ternary associative road-matching memory

This block is a small associative bank of track patterns. Each pattern keeps, for every detector layer, a superstrip address at full resolution together with a ternary mask covering the lowest address bits. When a mask bit is set, the matching region on that layer grows to twice the width. When it is clear, only the stored half of the region matches. Patterns are loaded one layer at a time through a write port. Hits are then streamed in as (layer, superstrip) words with valid/ready flow control. Every stored pattern compares each hit in the same cycle and records one sticky flag per layer.

An end-of-event word closes the event. The bank then counts the matched layers of each loaded pattern. Every pattern whose count reaches the programmed threshold is a road. Road identifiers leave one per cycle, lowest index first, on a valid/ready output, followed by a marker word. When the marker is taken, all layer flags clear in a single cycle and the bank accepts hits for the next event.

Top module: `road_cam`

## Requirements
- R1: A write with `wr_en` stores `wr_ss` and `wr_dc` for layer `wr_layer` of pattern `wr_pat` and marks that pattern as loaded. Writes to a layer index of `NLAYER` or more are ignored. A pattern that has never been written never appears as a road, even if its reset contents would match.
- R2: With a layer's mask bit k clear, address bit k is compared. A hit whose address differs from the stored address only in bit 0 does not set that layer's flag when mask bit 0 is clear.
- R3: With mask bit k set (bit k of `wr_dc` covers address bit k, for k below `DCW`), address bit k is ignored. With bit 0 set, hits with bit 0 at either value match that layer.
- R4: A hit is a word with `hit_eoe`=0, accepted when `hit_valid` and `hit_ready` are both high. It sets the flag of layer `hit_layer` in every pattern it matches. The flag stays set until the event is cleared, so repeated hits change nothing. A hit whose layer is `NLAYER` or above sets no flag.
- R5: A loaded pattern fires when its number of set layer flags is greater than or equal to `fire_thresh`, sampled when the end-of-event word is accepted. A threshold of 7 requires all seven default layers, and a threshold of 6 allows one layer to be missing.
- R6: After the end-of-event word (`hit_eoe`=1) is accepted, fired pattern indices appear on `road_id` with `road_last`=0 in strictly ascending order. They are followed by exactly one marker word with `road_last`=1 and `road_id`=0.
- R7: While `road_valid` is high and `road_ready` is low, `road_id` and `road_last` hold their values.
- R8: `hit_ready` is low from the cycle after the end-of-event word until the marker is accepted. It returns high in the next cycle, with all layer flags cleared.
- R9: One hit is compared against all patterns in parallel, so patterns that share an address on a layer all record that one hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_pat | input | PW | Pattern index to write |
| wr_layer | input | LW | Layer index to write |
| wr_ss | input | AW | Full-resolution superstrip address |
| wr_dc | input | DCW | Don't-care mask for the low address bits |
| fire_thresh | input | LW | Minimum number of matched layers for a road |
| hit_valid | input | 1 | Hit word valid |
| hit_ready | output | 1 | Bank accepts hit words |
| hit_eoe | input | 1 | Word is an end-of-event marker |
| hit_layer | input | LW | Hit layer number |
| hit_ss | input | AW | Hit superstrip address |
| road_valid | output | 1 | Output word valid |
| road_ready | input | 1 | Consumer accepts output word |
| road_id | output | PW | Fired pattern index (0 on marker) |
| road_last | output | 1 | End-of-event marker word |

## Verification
The bench feeds a hit in the vetoed half of a superstrip to two patterns that differ only in one mask bit. A bank that ignored the mask, or applied it to every bit, would report both roads or neither. It checks threshold 6 against threshold 7 on the same hits, and an empty bank with threshold 0, where a design that skipped the loaded check would emit roads from reset contents. It applies random backpressure to catch a scan that advances or changes its word while stalled. An empty event follows a busy one, so flags that are not cleared would show up as stale roads.

// File: rtl/road_cam.sv
module road_cam #(
  parameter int NPAT   = 64,
  parameter int NLAYER = 7,
  parameter int AW     = 16,
  parameter int LW     = 4,
  parameter int DCW    = 1,
  localparam int PW    = $clog2(NPAT),
  localparam int CW    = $clog2(NLAYER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_pat,
  input  logic [LW-1:0] wr_layer,
  input  logic [AW-1:0] wr_ss,
  input  logic [DCW-1:0] wr_dc,
  input  logic [LW-1:0] fire_thresh,
  input  logic          hit_valid,
  output logic          hit_ready,
  input  logic          hit_eoe,
  input  logic [LW-1:0] hit_layer,
  input  logic [AW-1:0] hit_ss,
  output logic          road_valid,
  input  logic          road_ready,
  output logic [PW-1:0] road_id,
  output logic          road_last
);

  logic [AW-1:0]     ss_q   [NPAT][NLAYER];
  logic [DCW-1:0]    dc_q   [NPAT][NLAYER];
  logic [NLAYER-1:0] flag_q [NPAT];
  logic [NLAYER-1:0] mv     [NPAT];
  logic [NPAT-1:0]   live_q, fired, pend_q;
  logic              scan_q, any;
  logic [PW-1:0]     sel;

  wire hit_take = hit_valid && !scan_q;
  wire eoe_take = hit_take && hit_eoe;
  wire clr      = scan_q && road_ready && !any;

  assign hit_ready  = !scan_q;
  assign road_valid = scan_q;
  assign any        = |pend_q;
  assign road_last  = !any;
  assign road_id    = any ? sel : '0;

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    logic [CW-1:0] cnt;

    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ss_q[p][l] <= '0;
          dc_q[p][l] <= '0;
        end else if (wr_en && wr_pat == PW'(p) && wr_layer == LW'(l)) begin
          ss_q[p][l] <= wr_ss;
          dc_q[p][l] <= wr_dc;
        end
      end
      assign mv[p][l] = hit_take && !hit_eoe && hit_layer == LW'(l) &&
                        (((hit_ss ^ ss_q[p][l]) & ~{{(AW-DCW){1'b0}}, dc_q[p][l]}) == '0);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[p] <= 1'b0;
        flag_q[p] <= '0;
      end else begin
        if (wr_en && wr_pat == PW'(p) && 32'(wr_layer) < NLAYER) live_q[p] <= 1'b1;
        if (clr) flag_q[p] <= '0;
        else     flag_q[p] <= flag_q[p] | mv[p];
      end
    end

    always_comb begin
      cnt = '0;
      for (int l = 0; l < NLAYER; l++) cnt = cnt + CW'(flag_q[p][l]);
    end

    assign fired[p] = live_q[p] && (32'(cnt) >= 32'(fire_thresh));
  end

  always_comb begin
    sel = '0;
    for (int i = NPAT - 1; i >= 0; i--) if (pend_q[i]) sel = PW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      pend_q <= '0;
    end else if (eoe_take) begin
      scan_q <= 1'b1;
      pend_q <= fired;
    end else if (scan_q && road_ready) begin
      if (any) pend_q[sel] <= 1'b0;
      else     scan_q <= 1'b0;
    end
  end

endmodule

module road_cam_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_ready,
  input logic          road_valid,
  input logic          road_ready,
  input logic [PW-1:0] road_id,
  input logic          road_last
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid && !road_ready |=> road_valid && $stable(road_id) && $stable(road_last));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid |-> !hit_ready);

  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid && !road_last && $past(road_valid && road_ready && !road_last)
    |-> road_id > $past(road_id));

  p_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid && road_last |-> road_id == '0);

  p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid && road_ready && road_last |=> hit_ready && !road_valid);

endmodule

bind road_cam road_cam_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_ready(hit_ready), .road_valid(road_valid),
  .road_ready(road_ready), .road_id(road_id), .road_last(road_last)
);

// File: tb/sim_road_cam.sv
module sim_road_cam;
  localparam int PERIOD = 10;
  localparam int NP = 64, NL = 7, AW = 16, LW = 4, PW = 6;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [PW-1:0] wr_pat = 0; logic [LW-1:0] wr_layer = 0;
  logic [AW-1:0] wr_ss = 0; logic [0:0] wr_dc = 0; logic [LW-1:0] fire_thresh = 7;
  logic hit_valid = 0, hit_eoe = 0; logic [LW-1:0] hit_layer = 0; logic [AW-1:0] hit_ss = 0;
  logic hit_ready, road_valid, road_last, road_ready = 0; logic [PW-1:0] road_id;

  always #(PERIOD/2) clk = ~clk;

  road_cam u0 (.*);

  int total = 0, bad = 0; bit done = 0;
  logic [AW-1:0] mss [NP][NL];
  bit mdc [NP][NL];
  bit mlive [NP];
  bit mflag [NP][NL];
  int exp_ids [NP]; int exp_n;
  int got_ids [NP+1]; int got_n;
  bit bp = 0;

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, expv); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_write(int p, int l, logic [AW-1:0] ss, bit dc);
    @(negedge clk);
    wr_en = 1; wr_pat = PW'(p); wr_layer = LW'(l); wr_ss = ss; wr_dc = dc;
    @(negedge clk); wr_en = 0;
    if (l < NL) begin mss[p][l] = ss; mdc[p][l] = dc; mlive[p] = 1; end
  endtask

  function automatic bit m_match(int p, int l, logic [AW-1:0] ss);
    logic [AW-1:0] msk = {{(AW-1){1'b1}}, ~mdc[p][l]};
    return ((ss ^ mss[p][l]) & msk) == '0;
  endfunction

  task automatic send_hit(int l, logic [AW-1:0] ss);
    @(negedge clk);
    hit_valid = 1; hit_eoe = 0; hit_layer = LW'(l); hit_ss = ss;
    @(negedge clk); hit_valid = 0;
    if (l < NL) for (int p = 0; p < NP; p++) if (m_match(p, l, ss)) mflag[p][l] = 1;
  endtask

  function automatic void model_expect(int th);
    exp_n = 0;
    for (int p = 0; p < NP; p++) begin
      int c = 0;
      for (int l = 0; l < NL; l++) c += int'(mflag[p][l]);
      if (mlive[p] && c >= th) begin exp_ids[exp_n] = p; exp_n++; end
    end
  endfunction

  task automatic end_event(int th, string req);
    bit fin = 0; int guard = 0; bit held = 0; int hid = 0;
    model_expect(th);
    @(negedge clk);
    fire_thresh = LW'(th); hit_valid = 1; hit_eoe = 1;
    @(negedge clk); hit_valid = 0; hit_eoe = 0;
    got_n = 0;
    while (!fin && guard < 2000) begin
      bit rr = bp ? 1'($urandom_range(0, 1)) : 1'b1;
      guard++;
      if (held) check(road_valid && road_id == PW'(hid), "R7", int'(road_id), hid);
      held = 0;
      road_ready = rr;
      if (road_valid) begin
        if (hit_ready) check(0, "R8", 1, 0);
        if (rr) begin
          if (road_last) begin
            check(road_id == 0, "R6", int'(road_id), 0);
            fin = 1;
          end else if (got_n < NP) begin
            got_ids[got_n] = int'(road_id); got_n++;
          end
        end else begin held = 1; hid = int'(road_id); end
      end
      if (!fin) @(negedge clk);
    end
    @(negedge clk); road_ready = 0;
    check(fin, "R6", int'(fin), 1);
    check(hit_ready && !road_valid, "R8", int'(hit_ready), 1);
    check(got_n == exp_n, req, got_n, exp_n);
    for (int i = 0; i < got_n && i < exp_n; i++)
      check(got_ids[i] == exp_ids[i], req, got_ids[i], exp_ids[i]);
    for (int p = 0; p < NP; p++) for (int l = 0; l < NL; l++) mflag[p][l] = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) begin
      mlive[p] = 0;
      for (int l = 0; l < NL; l++) begin mss[p][l] = 0; mdc[p][l] = 0; mflag[p][l] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(hit_ready == 1 && road_valid == 0, "R8 reset", int'(road_valid), 0);

    end_event(0, "R1 empty bank");

    for (int l = 0; l < NL; l++) begin
      do_write(5, l, 16'h0200 + AW'(l * 16), 0);
      do_write(9, l, 16'h0200 + AW'(l * 16), l == 2);
    end
    do_write(9, 8, 16'h0000, 0);

    for (int l = 0; l < NL; l++) send_hit(l, 16'h0200 + AW'(l * 16) ^ (l == 2 ? 16'h1 : 16'h0));
    end_event(7, "R2 R3 vetoed half vs dont-care");

    for (int l = 0; l < NL; l++) send_hit(l, 16'h0200 + AW'(l * 16) ^ (l == 2 ? 16'h1 : 16'h0));
    end_event(6, "R5 threshold 6");

    for (int l = 0; l < NL; l++) begin
      send_hit(l, 16'h0200 + AW'(l * 16));
      send_hit(l, 16'h0200 + AW'(l * 16));
    end
    send_hit(9, 16'h0200);
    end_event(7, "R4 R9 sticky and parallel");

    end_event(7, "R8 flags cleared");

    for (int l = 0; l < NL; l++) send_hit(l, 16'h0000);
    end_event(7, "R1 unloaded pattern");

    for (int p = 0; p < NP - 1; p++)
      for (int l = 0; l < NL; l++)
        do_write(p, l, 16'h1230 + AW'(2 * $urandom_range(0, 3)) + AW'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)));

    bp = 1;
    for (int e = 0; e < 40; e++) begin
      int th = $urandom_range(6, 7);
      for (int k = 0; k < 3; k++) begin
        int p = $urandom_range(0, NP - 2);
        for (int l = 0; l < NL; l++)
          send_hit(l, mss[p][l] ^ AW'($urandom_range(0, 3) == 0));
      end
      for (int k = 0; k < 5; k++)
        send_hit($urandom_range(0, 8), 16'h1230 + AW'($urandom_range(0, 7)));
      end_event(th, "R3 R5 R6 random");
    end

    finish_run();
  end
endmodule